// File: doc/BRIEF.md
# Page-Write Controller for a Parallel EEPROM

This block takes byte-write requests from a host over a valid/ready port and turns them into write strobes on the asynchronous bus of a parallel EEPROM. Bytes whose upper address bits name the same page are gathered into one page-load burst. Each byte is written with a write-enable pulse whose width, data setup and address hold are counted in system clocks and rounded up to whole cycles. Consecutive strobes of one burst are spaced no closer than the minimum byte-load cycle and no further apart than the byte-load window.

A burst closes in one of three ways. The host can mark a byte as final. A byte can arrive whose page differs from the page of the open burst. The window can run out with no new byte. After a burst closes, the controller holds off the host while the device programs. Depending on a parameter, it either waits a fixed worst-case time, or it watches the device's ready/busy pin and keeps that same time only as a fallback. Output enable is never asserted, because this block does no reads.

Top module: `eepw_ctrl`

## Requirements
- R1: After a reset with `rst_n` low, `host_ready` is 1 and `mem_we_n` and `mem_ce_n` are both 1.
- R2: A byte is accepted on a clock edge where `host_valid` and `host_ready` are both 1. On that edge `mem_addr`/`mem_data` take the host values and `mem_we_n` and `mem_ce_n` go low. `mem_we_n` stays low for exactly WP_CYC = ceil(max(WP_NS, DS_NS, AH_NS)/CLK_NS) cycles, and address and data hold still while it is low.
- R3: Within a burst, a write-enable falling edge comes no sooner than GAP_CYC = max(ceil(BLC_NS/CLK_NS), WP_CYC+1) cycles after the previous one. A byte that is offered early is stalled and then issued exactly GAP_CYC cycles after the previous falling edge.
- R4: The page is address bits [ADDR_W-1:PAGE_LSB] (bits 12..6 by default) of the first byte of a burst. While the burst waits for its next byte, an offered byte with another page sees `host_ready` = 0. It closes the burst (`mem_ce_n` goes high) on the next edge, and it is issued as the first byte of a new burst once programming is over.
- R5: If no byte is accepted within BL_CYC = floor(BL_NS/CLK_NS) cycles of the last write-enable falling edge, the burst closes: `mem_ce_n` goes high on edge BL_CYC after that falling edge.
- R6: A byte accepted with `host_last` = 1 closes the burst on the edge where its strobe ends. `mem_we_n` and `mem_ce_n` rise together.
- R7: In fixed-wait mode (BUSY_MODE = 0), `host_ready` stays 0 for PROG_CYC = BL_CYC + ceil(WC_NS/CLK_NS) cycles after the burst closes, regardless of `mem_rdy`.
- R8: In busy-pin mode (BUSY_MODE = 1), `mem_rdy` passes through a two-flop synchronizer. It is ignored during the first GUARD_CYC = BL_CYC + ceil(DB_NS/CLK_NS) cycles of the wait. After that, `host_ready` returns three edges after `mem_rdy` rises.
- R9: In busy-pin mode, if `mem_rdy` stays low, `host_ready` returns after PROG_CYC cycles, the same as in fixed-wait mode.
- R10: `mem_oe_n` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_valid | input | 1 | Host offers a byte |
| host_ready | output | 1 | Controller takes the offered byte on this edge |
| host_addr | input | ADDR_W | Byte address; upper bits select the page |
| host_data | input | DATA_W | Byte to write |
| host_last | input | 1 | Final byte of the page |
| mem_addr | output | ADDR_W | Device address bus |
| mem_data | output | DATA_W | Device data bus, driven for writes |
| mem_ce_n | output | 1 | Device chip enable, active low |
| mem_we_n | output | 1 | Device write enable, active low |
| mem_oe_n | output | 1 | Device output enable, held high |
| mem_rdy | input | 1 | Device ready (1) / busy (0), asynchronous |

## Verification
The bench offers the second byte of a burst at once and checks that its strobe lands exactly GAP_CYC cycles after the first. A design that ignored the byte-load minimum would strobe too early, and one that spaced strobes by WP_CYC alone would also fail. It holds `mem_rdy` high from the very start of programming, so a design without the post-close guard would release the host hundreds of cycles early. It lets a burst sit idle to find the exact edge where the window closes, and checks the timeout fallback. It offers a byte from a foreign page mid-burst: a design that merged it into the open page, or that dropped it, is caught by the address checks on the next strobe.

// File: rtl/eepw_pkg.sv
// Package: shared state type and cycle-rounding helpers for the page-write
// controller. Assumes all time values are given in whole nanoseconds.
package eepw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // no burst open, host may start one
        ST_STROBE = 2'd1,   // write enable held low
        ST_LOAD   = 2'd2,   // burst open, waiting for the next byte
        ST_PROG   = 2'd3    // device programming, host held off
    } eepw_state_e;

    // Round a minimum time up to whole clock cycles.
    function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                              input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    // Larger of two unsigned values.
    function automatic int unsigned max_u(input int unsigned a,
                                          input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eepw_count.sv
// Module: free-running up counter with synchronous clear that saturates at
// LIMIT. Used to time strobes, windows and the programming wait.
// Assumes LIMIT fits in W bits.
module eepw_count #(
    parameter int unsigned W     = 8,
    parameter int unsigned LIMIT = 255
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    // Count up each cycle, restart on clear, hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (cnt != LIM)
            cnt <= cnt + 1'b1;
    end

    // Timing base for R5/R7: below the limit the count advances by one.
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt != LIM) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/eepw_sync2.sv
// Module: two-flop synchronizer for the asynchronous ready/busy pin.
// Assumes the pin changes slowly compared with the clock.
module eepw_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic s1;

    // Shift the pin through two flops; resets to "busy".
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            q  <= 1'b0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end

endmodule

// File: rtl/eepw_ctrl.sv
// Module: page-write controller for a parallel EEPROM. Gathers same-page host
// bytes into one load burst, times the write strobes, and holds off the host
// while the device programs. Assumes the host keeps its fields steady while
// host_valid is high, and that WP_CYC < GAP_CYC <= BL_CYC.
module eepw_ctrl import eepw_pkg::*; #(
    parameter int unsigned ADDR_W    = 13,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned PAGE_LSB  = 6,
    parameter int unsigned CLK_NS    = 10,
    parameter int unsigned WP_NS     = 100,
    parameter int unsigned DS_NS     = 50,
    parameter int unsigned AH_NS     = 50,
    parameter int unsigned BLC_NS    = 200,
    parameter int unsigned BL_NS     = 30000,
    parameter int unsigned WC_NS     = 10000000,
    parameter int unsigned DB_NS     = 120,
    parameter int unsigned BUSY_MODE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              host_last,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    input  logic              mem_rdy
);
    localparam int unsigned WP_CYC    = ns_to_cyc(max_u(max_u(WP_NS, DS_NS), AH_NS), CLK_NS);
    localparam int unsigned BLC_CYC   = ns_to_cyc(BLC_NS, CLK_NS);
    localparam int unsigned GAP_CYC   = max_u(BLC_CYC, WP_CYC + 1);
    localparam int unsigned BL_CYC    = BL_NS / CLK_NS;
    localparam int unsigned WC_CYC    = ns_to_cyc(WC_NS, CLK_NS);
    localparam int unsigned DB_CYC    = ns_to_cyc(DB_NS, CLK_NS);
    localparam int unsigned PROG_CYC  = BL_CYC + WC_CYC;
    localparam int unsigned GUARD_CYC = BL_CYC + DB_CYC;
    localparam int unsigned SINCE_W   = $clog2(BL_CYC + 1);
    localparam int unsigned CNT_W     = $clog2(PROG_CYC + 1);
    localparam int unsigned PAGE_W    = ADDR_W - PAGE_LSB;

    localparam logic [SINCE_W-1:0] WP_END  = SINCE_W'(WP_CYC - 1);
    localparam logic [SINCE_W-1:0] WP_V    = SINCE_W'(WP_CYC);
    localparam logic [SINCE_W-1:0] GAP_MIN = SINCE_W'(GAP_CYC - 1);
    localparam logic [SINCE_W-1:0] WIN_END = SINCE_W'(BL_CYC - 1);
    localparam logic [CNT_W-1:0]   PROG_END = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0]   GUARD_V  = CNT_W'(GUARD_CYC);

    eepw_state_e        state_q;
    logic [PAGE_W-1:0]  page_q;
    logic               last_q;
    logic [SINCE_W-1:0] since_cnt;
    logic [CNT_W-1:0]   prog_cnt;
    logic               page_hit;
    logic               accept;
    logic               prog_done;

    // Cycles since the latest write-enable falling edge.
    eepw_count #(.W(SINCE_W), .LIMIT(BL_CYC)) u_since (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .cnt   (since_cnt)
    );

    // Cycles spent in the programming wait.
    eepw_count #(.W(CNT_W), .LIMIT(PROG_CYC)) u_prog (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_PROG),
        .cnt   (prog_cnt)
    );

    // Pick how the programming wait ends.
    generate
        if (BUSY_MODE != 0) begin : g_busy
            logic rdy_s;
            eepw_sync2 u_rdy_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (mem_rdy),
                .q     (rdy_s)
            );
            assign prog_done = (prog_cnt == PROG_END) ||
                               (prog_cnt >= GUARD_V && rdy_s);
        end else begin : g_fixed
            logic unused_rdy;
            assign unused_rdy = mem_rdy;
            assign prog_done  = (prog_cnt == PROG_END);
        end
    endgenerate

    // Decide whether the offered byte can be taken on this edge.
    always_comb begin
        page_hit   = (host_addr[ADDR_W-1:PAGE_LSB] == page_q);
        host_ready = (state_q == ST_IDLE) ||
                     (state_q == ST_LOAD && page_hit && since_cnt >= GAP_MIN);
        accept     = host_valid && host_ready;
    end

    assign mem_oe_n = 1'b1;

    // Burst sequencer: strobe timing, burst closing and programming wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            page_q   <= '0;
            last_q   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
            mem_we_n <= 1'b1;
            mem_ce_n <= 1'b1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        page_q   <= host_addr[ADDR_W-1:PAGE_LSB];
                        last_q   <= host_last;
                        mem_addr <= host_addr;
                        mem_data <= host_data;
                        mem_we_n <= 1'b0;
                        mem_ce_n <= 1'b0;
                        state_q  <= ST_STROBE;
                    end
                end
                ST_STROBE: begin
                    if (since_cnt == WP_END) begin
                        mem_we_n <= 1'b1;
                        if (last_q) begin
                            mem_ce_n <= 1'b1;
                            state_q  <= ST_PROG;
                        end else begin
                            state_q  <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: begin
                    if (accept) begin
                        last_q   <= host_last;
                        mem_addr <= host_addr;
                        mem_data <= host_data;
                        mem_we_n <= 1'b0;
                        state_q  <= ST_STROBE;
                    end else if ((host_valid && !page_hit) || since_cnt >= WIN_END) begin
                        mem_ce_n <= 1'b1;
                        state_q  <= ST_PROG;
                    end
                end
                default: begin
                    if (prog_done)
                        state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // R2: each strobe lasts exactly WP_CYC cycles.
    p_we_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (since_cnt == WP_V));

    // R2: chip enable covers the whole strobe.
    p_ce_cover_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    // R2: address and data hold still while write enable is low.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$fell(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_data)));

    // R3: strobes of one burst keep the minimum spacing.
    p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_we_n) && !$past(mem_ce_n)) |-> ($past(since_cnt) >= GAP_MIN));

    // R4: every strobe in a burst stays in the captured page.
    p_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_we_n) && !$past(mem_ce_n)) |->
        (mem_addr[ADDR_W-1:PAGE_LSB] == $past(mem_addr[ADDR_W-1:PAGE_LSB])));

    // R7: the programming wait never exceeds its bound.
    p_prog_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG) |-> (prog_cnt <= PROG_END));

endmodule

// File: tb/eepw_ctrl_tb_top.sv
`timescale 1ns/1ps
module eepw_ctrl_tb_top;
    localparam int CLK_NS = 10;
    localparam int BL_NS  = 3000;
    localparam int WC_NS  = 5000;
    // Expected cycle counts, from the requirement formulas.
    localparam int WP_C    = (100 + CLK_NS - 1) / CLK_NS;
    localparam int GAP_C   = ((200 + CLK_NS - 1) / CLK_NS > WP_C + 1) ? (200 + CLK_NS - 1) / CLK_NS : WP_C + 1;
    localparam int BL_C    = BL_NS / CLK_NS;
    localparam int PROG_C  = BL_C + (WC_NS + CLK_NS - 1) / CLK_NS;
    localparam int GUARD_C = BL_C + (120 + CLK_NS - 1) / CLK_NS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic [12:0] host_addr = '0;
    logic [7:0]  host_data = '0;
    logic        host_last = 1'b0;
    logic        rdy = 1'b0;
    logic        host_ready, mem_ce_n, mem_we_n, mem_oe_n;
    logic [12:0] mem_addr;
    logic [7:0]  mem_data;
    logic        f_ready, f_ce_n, f_we_n, f_oe_n;
    logic [12:0] f_addr;
    logic [7:0]  f_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int at = 0;
    int w;

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    eepw_ctrl #(.CLK_NS(CLK_NS), .BL_NS(BL_NS), .WC_NS(WC_NS), .BUSY_MODE(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
        .host_addr(host_addr), .host_data(host_data), .host_last(host_last),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_rdy(rdy));

    eepw_ctrl #(.CLK_NS(CLK_NS), .BL_NS(BL_NS), .WC_NS(WC_NS), .BUSY_MODE(0)) dut_f_i (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(f_ready),
        .host_addr(host_addr), .host_data(host_data), .host_last(host_last),
        .mem_addr(f_addr), .mem_data(f_data), .mem_ce_n(f_ce_n),
        .mem_we_n(f_we_n), .mem_oe_n(f_oe_n), .mem_rdy(rdy));

    // {addr, data, last, expect a programming wait before acceptance}
    localparam logic [22:0] VEC [8] = '{
        {13'h0040, 8'hA1, 1'b0, 1'b0},
        {13'h0041, 8'hB2, 1'b0, 1'b0},
        {13'h007F, 8'hC3, 1'b1, 1'b0},
        {13'h0080, 8'hD4, 1'b0, 1'b1},
        {13'h00BF, 8'hE5, 1'b0, 1'b0},
        {13'h1FC0, 8'hF6, 1'b0, 1'b1},
        {13'h1FFF, 8'h07, 1'b1, 1'b0},
        {13'h0000, 8'h18, 1'b0, 1'b1}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Offer one byte, wait for acceptance; returns just after negedge 1.
    task automatic send(input logic [12:0] a, input logic [7:0] d, input bit l,
                        output int waited);
        @(negedge clk);
        host_valid = 1'b1; host_addr = a; host_data = d; host_last = l;
        #1;
        waited = 0;
        while (!host_ready) begin
            @(negedge clk); #1;
            waited++;
        end
        @(posedge clk);
        @(negedge clk);
        host_valid = 1'b0;
        #1;
        at = 1;
    endtask

    // Advance to the m-th negedge after the last acceptance edge.
    task automatic goto(input int m);
        repeat (m - at) @(negedge clk);
        #1;
        at = m;
    endtask

    task automatic wait_idle();
        while (!host_ready) begin
            @(negedge clk); #1;
        end
    endtask

    // Strobe monitor: width, spacing, page and stability on the device bus.
    logic        prev_we = 1'b1, prev_ce = 1'b1;
    int          fall_cyc = 0, last_gap = 0;
    logic [12:0] fall_addr;
    logic [7:0]  fall_data;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_we && !mem_we_n) begin
                if (!prev_ce) begin
                    last_gap = cyc - fall_cyc;
                    check(last_gap >= GAP_C, "R3", "strobe spacing", last_gap, GAP_C);
                    check(mem_addr[12:6] == fall_addr[12:6], "R4", "page in burst", mem_addr[12:6], fall_addr[12:6]);
                end
                fall_cyc  = cyc;
                fall_addr = mem_addr;
                fall_data = mem_data;
            end else if (!prev_we && !mem_we_n) begin
                check(mem_addr == fall_addr && mem_data == fall_data, "R2", "bus stable in strobe",
                      {mem_addr, mem_data}, {fall_addr, fall_data});
            end
            if (!prev_we && mem_we_n)
                check(cyc - fall_cyc == WP_C, "R2", "strobe width", cyc - fall_cyc, WP_C);
            if (!mem_we_n)
                check(!mem_ce_n, "R2", "ce low during strobe", mem_ce_n, 0);
            if (!mem_oe_n)
                check(0, "R10", "oe asserted", mem_oe_n, 1);
            prev_we = mem_we_n;
            prev_ce = mem_ce_n;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", "run did not finish", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // Reset state (R1, R10)
        repeat (4) @(negedge clk);
        #1;
        check(host_ready == 1'b1, "R1", "ready in reset", host_ready, 1);
        check(mem_we_n == 1'b1 && mem_ce_n == 1'b1, "R1", "strobes idle", {mem_we_n, mem_ce_n}, 3);
        check(mem_oe_n == 1'b1, "R10", "oe high", mem_oe_n, 1);
        @(negedge clk);
        rst_n = 1'b1;

        // Ready pin high from the start: guard must hold (R8); fixed mode ignores it (R7)
        rdy = 1'b1;
        send(13'h0100, 8'h5A, 1'b1, w);
        check(mem_addr == 13'h0100 && mem_data == 8'h5A, "R2", "bus after accept", {mem_addr, mem_data}, {13'h0100, 8'h5A});
        check(mem_we_n == 1'b0 && mem_ce_n == 1'b0, "R2", "strobe starts", {mem_we_n, mem_ce_n}, 0);
        goto(WP_C);
        check(mem_we_n == 1'b0, "R2", "we still low", mem_we_n, 0);
        goto(WP_C + 1);
        check(mem_we_n == 1'b1 && mem_ce_n == 1'b1, "R6", "last byte closes burst", {mem_we_n, mem_ce_n}, 3);
        goto(WP_C + GUARD_C + 1);
        check(host_ready == 1'b0, "R8", "guard ignores ready pin", host_ready, 0);
        goto(WP_C + GUARD_C + 2);
        check(host_ready == 1'b1, "R8", "ready after guard", host_ready, 1);
        check(f_ready == 1'b0, "R7", "fixed mode still waiting", f_ready, 0);
        goto(WP_C + PROG_C);
        check(f_ready == 1'b0, "R7", "fixed wait last cycle", f_ready, 0);
        goto(WP_C + PROG_C + 1);
        check(f_ready == 1'b1, "R7", "fixed wait over", f_ready, 1);
        rdy = 1'b0;

        // Ready pin rises late (R8)
        send(13'h0200, 8'h11, 1'b1, w);
        goto(400);
        rdy = 1'b1;
        goto(402);
        check(host_ready == 1'b0, "R8", "sync latency", host_ready, 0);
        goto(403);
        check(host_ready == 1'b1, "R8", "ready three edges after pin", host_ready, 1);
        rdy = 1'b0;

        // Window expiry and timeout fallback (R5, R9)
        send(13'h0300, 8'h22, 1'b0, w);
        goto(BL_C);
        check(mem_ce_n == 1'b0, "R5", "burst open in window", mem_ce_n, 0);
        goto(BL_C + 1);
        check(mem_ce_n == 1'b1, "R5", "window closes burst", mem_ce_n, 1);
        goto(BL_C + PROG_C);
        check(host_ready == 1'b0, "R9", "timeout last cycle", host_ready, 0);
        goto(BL_C + PROG_C + 1);
        check(host_ready == 1'b1, "R9", "timeout over", host_ready, 1);

        // Early second byte lands exactly on the minimum spacing (R3)
        send(13'h0400, 8'h33, 1'b0, w);
        send(13'h0401, 8'h44, 1'b1, w);
        check(last_gap == GAP_C, "R3", "exact spacing", last_gap, GAP_C);
        check(mem_addr == 13'h0401 && mem_data == 8'h44, "R2", "second byte on bus", {mem_addr, mem_data}, {13'h0401, 8'h44});
        wait_idle();

        // Foreign page mid-burst (R4)
        send(13'h0500, 8'h55, 1'b0, w);
        goto(30);
        check(mem_ce_n == 1'b0, "R4", "burst open before mismatch", mem_ce_n, 0);
        host_valid = 1'b1; host_addr = 13'h0600; host_data = 8'h66; host_last = 1'b1;
        #1;
        check(host_ready == 1'b0, "R4", "foreign page stalled", host_ready, 1'b0);
        goto(31);
        check(mem_ce_n == 1'b1, "R4", "mismatch closes burst", mem_ce_n, 1);
        wait_idle();
        @(posedge clk);
        @(negedge clk);
        host_valid = 1'b0;
        #1;
        check(mem_addr == 13'h0600 && mem_data == 8'h66 && mem_we_n == 1'b0, "R4", "held byte issued",
              {mem_addr, mem_data, mem_we_n}, {13'h0600, 8'h66, 1'b0});
        wait_idle();

        // Vector table: grouping by page, last flag and mismatch (R2, R3, R4, R6)
        for (int i = 0; i < 8; i++) begin
            send(VEC[i][22:10], VEC[i][9:2], VEC[i][1], w);
            if (VEC[i][0])
                check(w >= PROG_C, "R4", $sformatf("vector %0d new burst wait", i), w, PROG_C);
            else
                check(w <= GAP_C, "R3", $sformatf("vector %0d same burst wait", i), w, GAP_C);
            check(mem_addr == VEC[i][22:10] && mem_data == VEC[i][9:2], "R2",
                  $sformatf("vector %0d bus", i), {mem_addr, mem_data}, {VEC[i][22:10], VEC[i][9:2]});
        end
        wait_idle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule